// File: doc/BRIEF.md
# Companded PCM mute and pad stage

This block post-processes one 8-bit companded voice sample per frame on the decoder side of a voice channel, just before the sample is serialized. A per-channel attenuation enable selects one of two treatments. A shared mode input picks which one applies. In mute mode the sample is replaced by the idle-channel code of the active companding law. In pad mode the sample is lowered by 12 dB. To do this it is expanded to linear, divided by four with an arithmetic shift, and compressed again under the same law.

A law input selects A-law or μ-law. A through input makes the stage transparent: the sample passes unmodified and the attenuation controls are ignored. The decision is made at one processing point per frame, a fixed number of clock cycles after the frame sync rises. The bit-clock rate has no effect on that point. At the processing point the sample and every control are sampled together and the result is registered with a one-cycle valid strobe.

Top module: `pcm_pad_mute`

## Requirements
- R1: While reset is asserted and until the first processing point, `code_vld` is 0 and `code_out` is 8'h00.
- R2: The processing point falls on the rising clock edge exactly OFFSET_CYC edges after the edge that first samples `frame_sync` high after it was low. `code_vld` is high for exactly the one cycle that follows that edge, and low at all other times.
- R3: The sample and all controls are used only as they stand at the processing point. Their values in any other cycle have no effect on the output.
- R4: With `thru_en` = 0 and `atten_en` = 0, the registered output equals the input sample.
- R5: In mute mode (`pad_mode` = 0) with `atten_en` = 1 under μ-law (`law_a` = 0), the output is 8'hFF for every input sample.
- R6: In mute mode with `atten_en` = 1 under A-law (`law_a` = 1), the output is 8'hD5 for every input sample.
- R7: In pad mode (`pad_mode` = 1) with `atten_en` = 1 under μ-law, the output is computed in three steps. First the code is expanded: invert all bits; bit 7 set means negative; bits 6:4 are the exponent e and bits 3:0 the mantissa m; magnitude = ((2m+33)<<e)-33. The value is then shifted arithmetically right by 2. It is then re-compressed with the inverse rule, where the segment is found from magnitude+33 clipped to 8191.
- R8: In pad mode with `atten_en` = 1 under A-law, the output is computed in three steps. First the code is expanded: XOR with 8'h55; bit 7 set means positive; for e = 0 the magnitude is 2m+1, otherwise (2m+33)<<(e-1). The value is then shifted arithmetically right by 2. It is then re-compressed, where a negative value v uses magnitude -v-1, clipped to 4095.
- R9: With `thru_en` = 1, the output equals the input sample whatever `atten_en`, `pad_mode` and `law_a` are.
- R10: A new rise of `frame_sync` while a processing point is pending restarts the count, so only the later point occurs.
- R11: Between processing points, `code_out` holds its last value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_sync | input | 1 | Frame sync; its rising edge starts the offset count |
| law_a | input | 1 | 1 = A-law, 0 = μ-law |
| pad_mode | input | 1 | 1 = pad (12 dB loss), 0 = mute (idle code) |
| atten_en | input | 1 | Applies the selected mute or pad treatment |
| thru_en | input | 1 | Through mode: sample passes unchanged |
| code_in | input | 8 | Decoded companded sample |
| code_out | output | 8 | Processed companded sample, registered |
| code_vld | output | 1 | One-cycle strobe per processing point |

## Verification
The hardest situation to reach is a control that changes in the cycles around the processing point. The output must reflect only the value present on the deciding edge. A sync rise that lands while a point is still pending is similarly hard to bring about. To reach these, a random phase redraws the sample and every control on every cycle of each frame. A separate phase pulses the sync a second time partway through the offset count. Every one of the 256 codes is swept under both laws in each of the four treatments, so the segment boundaries of the round trip through linear are all reached.

// File: rtl/pcm_pad_mute_pkg.sv
package pcm_pad_mute_pkg;
    localparam int CODE_W  = 8;
    localparam int LIN_W   = 14;
    localparam int EXP_W   = 3;
    localparam int MANT_W  = 4;
    localparam logic [CODE_W-1:0] IDLE_MU = 8'hFF;
    localparam logic [CODE_W-1:0] IDLE_A  = 8'hD5;
    localparam logic [CODE_W-1:0] A_XOR   = 8'h55;
    localparam int MU_BIAS  = 33;
    localparam int MU_CLIP  = 8191;
    localparam int A_CLIP   = 4095;

    typedef struct packed {
        logic [CODE_W-1:0] code;
        logic              vld;
    } out_state_t;
endpackage

// File: rtl/pcm_expand.sv
module pcm_expand
    import pcm_pad_mute_pkg::*;
(
    input  logic [CODE_W-1:0]        code,
    input  logic                     law_a,
    output logic signed [LIN_W-1:0]  lin
);
    logic [CODE_W-1:0] c_d;
    logic [EXP_W-1:0]  exp_d;
    logic [MANT_W-1:0] mant_d;
    logic [LIN_W-1:0]  base_d;
    logic [LIN_W-1:0]  mag_d;
    logic              neg_d;

    always_comb begin
        c_d    = law_a ? (code ^ A_XOR) : ~code;
        exp_d  = c_d[6:4];
        mant_d = c_d[3:0];
        if (law_a) begin
            neg_d  = ~c_d[7];
            base_d = LIN_W'({mant_d, 1'b1});
            if (exp_d == '0) begin
                mag_d = base_d;
            end else begin
                mag_d = (base_d + LIN_W'(32)) << (exp_d - EXP_W'(1));
            end
        end else begin
            neg_d  = c_d[7];
            base_d = LIN_W'({mant_d, 1'b0}) + LIN_W'(MU_BIAS);
            mag_d  = (base_d << exp_d) - LIN_W'(MU_BIAS);
        end
        lin = neg_d ? -$signed(mag_d) : $signed(mag_d);
    end
endmodule

// File: rtl/pcm_compress.sv
module pcm_compress
    import pcm_pad_mute_pkg::*;
(
    input  logic signed [LIN_W-1:0] lin,
    input  logic                    law_a,
    output logic [CODE_W-1:0]       code
);
    localparam int V_W = LIN_W + 1;

    logic              neg_d;
    logic [V_W-1:0]    v_mu_d;
    logic [V_W-1:0]    v_a_d;
    logic [V_W-1:0]    sh_d;
    logic [EXP_W-1:0]  e_mu_d;
    logic [EXP_W-1:0]  e_a_d;
    logic [MANT_W-1:0] m_mu_d;
    logic [MANT_W-1:0] m_a_d;

    always_comb begin
        neg_d = lin[LIN_W-1];
        // mu-law: biased magnitude, clipped
        v_mu_d = neg_d ? V_W'(-lin) : V_W'(lin);
        v_mu_d = v_mu_d + V_W'(MU_BIAS);
        if (v_mu_d > V_W'(MU_CLIP)) v_mu_d = V_W'(MU_CLIP);
        e_mu_d = '0;
        for (int i = 1; i < 8; i++) begin
            if (v_mu_d[5+i]) e_mu_d = EXP_W'(i);
        end
        sh_d   = v_mu_d >> ({1'b0, e_mu_d} + 4'd1);
        m_mu_d = sh_d[MANT_W-1:0];
        // A-law: ones-complement magnitude for negatives, clipped
        v_a_d = neg_d ? V_W'(~lin) : V_W'(lin);
        if (v_a_d > V_W'(A_CLIP)) v_a_d = V_W'(A_CLIP);
        e_a_d = '0;
        for (int i = 1; i < 8; i++) begin
            if (v_a_d[4+i]) e_a_d = EXP_W'(i);
        end
        if (e_a_d == '0) begin
            m_a_d = v_a_d[4:1];
        end else begin
            sh_d  = v_a_d >> e_a_d;
            m_a_d = sh_d[MANT_W-1:0];
        end
        if (law_a) code = {~neg_d, e_a_d, m_a_d} ^ A_XOR;
        else       code = ~{neg_d, e_mu_d, m_mu_d};
    end
endmodule

// File: rtl/pcm_frame_timer.sv
module pcm_frame_timer #(
    parameter int OFFSET_CYC = 6
) (
    input  logic clk,
    input  logic rst_n,
    input  logic frame_sync,
    output logic fire
);
    localparam int CNT_W = (OFFSET_CYC > 1) ? $clog2(OFFSET_CYC) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(OFFSET_CYC - 1);

    typedef struct packed {
        logic             sync;
        logic             busy;
        logic [CNT_W-1:0] cnt;
    } tmr_state_t;

    tmr_state_t st_d, st_q;

    assign fire = st_q.busy && (st_q.cnt == LAST);

    always_comb begin
        st_d      = st_q;
        st_d.sync = frame_sync;
        if (frame_sync && !st_q.sync) begin
            st_d.busy = 1'b1;
            st_d.cnt  = '0;
        end else if (fire) begin
            st_d.busy = 1'b0;
            st_d.cnt  = '0;
        end else if (st_q.busy) begin
            st_d.cnt = st_q.cnt + CNT_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/pcm_pad_mute.sv
module pcm_pad_mute
    import pcm_pad_mute_pkg::*;
#(
    parameter int OFFSET_CYC = 6,
    parameter int PAD_SHIFT  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_sync,
    input  logic              law_a,
    input  logic              pad_mode,
    input  logic              atten_en,
    input  logic              thru_en,
    input  logic [CODE_W-1:0] code_in,
    output logic [CODE_W-1:0] code_out,
    output logic              code_vld
);
    logic                    fire;
    logic signed [LIN_W-1:0] lin;
    logic signed [LIN_W-1:0] lin_pad;
    logic [CODE_W-1:0]       pad_code;
    out_state_t              st_d, st_q;

    pcm_frame_timer #(.OFFSET_CYC(OFFSET_CYC)) u_timer (
        .clk(clk), .rst_n(rst_n), .frame_sync(frame_sync), .fire(fire)
    );

    pcm_expand u_expand (.code(code_in), .law_a(law_a), .lin(lin));

    assign lin_pad = lin >>> PAD_SHIFT;

    pcm_compress u_compress (.lin(lin_pad), .law_a(law_a), .code(pad_code));

    always_comb begin
        st_d     = st_q;
        st_d.vld = 1'b0;
        if (fire) begin
            st_d.vld = 1'b1;
            if (thru_en || !atten_en) begin
                st_d.code = code_in;
            end else if (!pad_mode) begin
                st_d.code = law_a ? IDLE_A : IDLE_MU;
            end else begin
                st_d.code = pad_code;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign code_out = st_q.code;
    assign code_vld = st_q.vld;
endmodule

// File: rtl/pcm_pad_mute_chk.sv
module pcm_pad_mute_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       law_a,
    input logic       pad_mode,
    input logic       atten_en,
    input logic       thru_en,
    input logic [7:0] code_in,
    input logic [7:0] code_out,
    input logic       code_vld
);
    a_r2_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        code_vld |=> !code_vld);

    a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !code_vld |-> $stable(code_out));

    a_r4_pass: assert property (@(posedge clk) disable iff (!rst_n)
        (code_vld && $past(!atten_en && !thru_en)) |-> code_out == $past(code_in));

    a_r9_thru: assert property (@(posedge clk) disable iff (!rst_n)
        (code_vld && $past(thru_en)) |-> code_out == $past(code_in));

    a_r5_idle_mu: assert property (@(posedge clk) disable iff (!rst_n)
        (code_vld && $past(atten_en && !pad_mode && !thru_en && !law_a)) |-> code_out == 8'hFF);

    a_r6_idle_a: assert property (@(posedge clk) disable iff (!rst_n)
        (code_vld && $past(atten_en && !pad_mode && !thru_en && law_a)) |-> code_out == 8'hD5);
endmodule

bind pcm_pad_mute pcm_pad_mute_chk u_chk (
    .clk(clk), .rst_n(rst_n), .law_a(law_a), .pad_mode(pad_mode),
    .atten_en(atten_en), .thru_en(thru_en), .code_in(code_in),
    .code_out(code_out), .code_vld(code_vld)
);

// File: tb/pcm_pad_mute_tb.sv
`timescale 1ns/1ps
module pcm_pad_mute_tb;
    localparam int OFFSET = 6;
    localparam int FRAME  = 16;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       frame_sync = 1'b0;
    logic       law_a = 1'b0, pad_mode = 1'b0, atten_en = 1'b0, thru_en = 1'b0;
    logic [7:0] code_in = 8'h00;
    logic [7:0] code_out;
    logic       code_vld;

    int total = 0, bad = 0;
    bit done = 0;

    // reference model state
    int    m_left = 0;
    bit    m_prev = 0;
    bit    exp_vld = 0;
    int    exp_code = 0;
    string m_tag = "R4";
    string phase = "R1";

    always #2 clk = ~clk;

    pcm_pad_mute #(.OFFSET_CYC(OFFSET), .PAD_SHIFT(2)) u_dut (
        .clk(clk), .rst_n(rst_n), .frame_sync(frame_sync), .law_a(law_a),
        .pad_mode(pad_mode), .atten_en(atten_en), .thru_en(thru_en),
        .code_in(code_in), .code_out(code_out), .code_vld(code_vld)
    );

    function automatic int mu_dec(int cw);
        int c = (~cw) & 255;
        int e = (c >> 4) & 7;
        int m = c & 15;
        int mag = ((2 * m + 33) << e) - 33;
        return (c & 128) ? -mag : mag;
    endfunction

    function automatic int mu_enc(int x);
        int s = (x < 0) ? 1 : 0;
        int v = ((x < 0) ? -x : x) + 33;
        int e = 0;
        if (v > 8191) v = 8191;
        while (e < 7 && v >= (64 << e)) e++;
        return (~((s << 7) | (e << 4) | ((v >> (e + 1)) & 15))) & 255;
    endfunction

    function automatic int a_dec(int cw);
        int c = cw ^ 85;
        int e = (c >> 4) & 7;
        int m = c & 15;
        int mag = (e == 0) ? (2 * m + 1) : ((2 * m + 33) << (e - 1));
        return (c & 128) ? mag : -mag;
    endfunction

    function automatic int a_enc(int x);
        int p = (x >= 0) ? 1 : 0;
        int v = (x >= 0) ? x : (-x - 1);
        int e = 0;
        int m;
        if (v > 4095) v = 4095;
        if (v >= 32) begin
            e = 1;
            while (e < 7 && v >= (32 << e)) e++;
        end
        m = (e == 0) ? ((v >> 1) & 15) : ((v >> e) & 15);
        return (((p << 7) | (e << 4) | m) ^ 85) & 255;
    endfunction

    task automatic check(bit ok, string req, int act, int expv, string what);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
        end
    endtask

    // one clock: compare at negedge, drive, then update model at posedge
    task automatic step(bit sy, int cw, bit la, bit pm, bit en, bit th);
        @(negedge clk);
        check(code_vld == exp_vld, (phase != "") ? phase : "R2", code_vld, exp_vld, "strobe");
        if (exp_vld)
            check(code_out == exp_code[7:0], (phase != "") ? phase : m_tag, code_out, exp_code, "data");
        else
            check(code_out == exp_code[7:0], (phase != "") ? phase : "R11", code_out, exp_code, "hold");
        frame_sync = sy; code_in = cw[7:0]; law_a = la; pad_mode = pm; atten_en = en; thru_en = th;
        @(posedge clk);
        if (!rst_n) begin
            m_left = 0; m_prev = 0; exp_vld = 0; exp_code = 0;
        end else begin
            bit fire_now = (m_left == 1);
            if (sy && !m_prev) m_left = OFFSET;
            else if (m_left > 0) m_left--;
            m_prev = sy;
            exp_vld = fire_now;
            if (fire_now) begin
                if (th) begin exp_code = cw; m_tag = "R9"; end
                else if (!en) begin exp_code = cw; m_tag = "R4"; end
                else if (!pm) begin exp_code = la ? 'hD5 : 'hFF; m_tag = la ? "R6" : "R5"; end
                else begin
                    exp_code = la ? a_enc(a_dec(cw) >>> 2) : mu_enc(mu_dec(cw) >>> 2);
                    m_tag = la ? "R8" : "R7";
                end
            end
        end
    endtask

    task automatic frame(int cw, bit la, bit pm, bit en, bit th);
        for (int i = 0; i < FRAME; i++) step(i < 2, cw, la, pm, en, th);
    endtask

    initial begin
        // R1: reset state
        phase = "R1";
        for (int i = 0; i < 4; i++) step(0, 'hA5, 1, 1, 1, 0);
        rst_n = 1'b1;
        for (int i = 0; i < 4; i++) step(0, 'h3C, 0, 0, 1, 0);
        // R4..R9: full code sweep under both laws and all treatments
        phase = "";
        for (int la = 0; la < 2; la++)
            for (int md = 0; md < 4; md++)
                for (int cw = 0; cw < 256; cw++)
                    frame(cw, la[0], md == 2, md != 0 && md != 3, md == 3);
        // R3: every input redrawn on every cycle
        phase = "R3";
        for (int f = 0; f < 300; f++)
            for (int i = 0; i < FRAME; i++)
                step(i < 2, $urandom_range(255), $urandom_range(1), $urandom_range(1),
                     $urandom_range(1), ($urandom_range(3) == 0));
        // R10: second sync rise while a point is pending
        phase = "R10";
        for (int f = 0; f < 20; f++)
            for (int i = 0; i < 24; i++)
                step(i == 0 || i == 3 + (f % 3), 16 * f + i, f[0], 1, 1, 0);
        phase = "R11";
        for (int i = 0; i < FRAME; i++) step(0, $urandom_range(255), 1, 0, 1, 1);
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule